// File: doc/BRIEF.md
# Register Command Byte Parser

The parser sits behind a serial control-port shifter and turns its byte stream into write cycles on a register and memory bus. The shifter presents one byte at a time with `rx_valid`. It pulses `rx_end` when a transaction closes, either on a stop condition or when the select line is released. Every transaction opens with a three-byte header. The header carries a device identifier, a direction bit and a 12-bit target address.

After the header, the parser collects data bytes, most significant byte first. The target address alone sets how many bytes make up one word. Parameter memory words take four bytes, program memory words take five, and control registers take two. Leading pad bits are removed before the word is issued on `wr_data`, together with a one-cycle `wr_en` strobe. If more bytes follow a finished word, they form the next word at the next address. That address may sit in a different region, so the word length can change in the middle of a burst.

Top module: `cmd_byte_parser`

## Requirements
- R1: While reset is held, and in the first cycle after it, `wr_en` is 0, and the first accepted byte is taken as header byte 0.
- R2: Header byte 0 carries the device identifier in bits 7:1 and the direction in bit 0, where 1 means read. Header byte 1 bits 3:0 give target address bits 11:8, and its bits 7:4 are ignored. Header byte 2 gives address bits 7:0.
- R3: Addresses 0 to 1023 are parameter memory. A word there takes 4 bytes, and `wr_data` holds only the low 28 bits received, with bits 39:28 zero. The top nibble of the first data byte is therefore dropped.
- R4: Addresses 1024 to 2047 are program memory. A word there takes 5 bytes, and all 40 bits appear on `wr_data`.
- R5: Addresses 2048 and above are control registers. A word there takes 2 bytes, high byte first, and appears on `wr_data[15:0]` with bits 39:16 zero.
- R6: In the cycle after the last byte of a word is accepted, `wr_en` is 1 for exactly one cycle, with the word's address on `wr_addr` and its data on `wr_data`.
- R7: Bytes that follow a complete word, with no end strobe in between, form the next word at the address plus one, and no new header is needed.
- R8: When a burst crosses a region boundary, the byte count for the new word follows the region of the new address.
- R9: If the identifier in header byte 0 differs from `dev_id`, the parser ignores every byte until `rx_end` and issues no write.
- R10: If the header byte 0 has direction bit 0 set to 1, the parser ignores every byte until `rx_end` and issues no write.
- R11: `rx_end` discards a partially received word without a write, and the next byte is taken as header byte 0. A byte that arrives in the same cycle as `rx_end` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_id | input | 7 | Identifier this device answers to |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | Transaction end strobe |
| wr_en | output | 1 | Write strobe, one cycle per word |
| wr_addr | output | 12 | Target address of the write |
| wr_data | output | 40 | Word with its padding removed |

## Verification
Some properties hold on every cycle, and the assertions check those. They check that write strobes never come in adjacent cycles, and that a strobe follows only a byte accepted without an end strobe. They check that parameter and register words always carry zero pad bits. They also check that an ignored transaction and an end strobe produce no write in the cycle that follows. Other behaviour only shows up over whole scenarios, and the bench covers it. This includes the byte count chosen per region, the most-significant-byte-first assembly, the address increment within a burst, the length change when a burst crosses into a new region, and recovery into a fresh header after a foreign, read or truncated transaction.

// File: rtl/cmd_byte_parser.sv
module cmd_byte_parser #(
  parameter int ID_W        = 7,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 40,
  parameter int PARAM_END   = 1024,
  parameter int PROG_END    = 2048,
  parameter int PARAM_BYTES = 4,
  parameter int PROG_BYTES  = 5,
  parameter int REG_BYTES   = 2,
  parameter int PARAM_BITS  = 28,
  parameter int REG_BITS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_end,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(DATA_W / 8 + 1);
  localparam int HI_W  = ADDR_W - 8;

  typedef enum logic [2:0] {S_HDR0, S_HDR1, S_HDR2, S_DATA, S_SKIP} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] acc;

  wire in_param = addr < ADDR_W'(PARAM_END);
  wire in_prog  = !in_param && addr < ADDR_W'(PROG_END);

  wire [CNT_W-1:0] need = in_param ? CNT_W'(PARAM_BYTES) :
                          in_prog  ? CNT_W'(PROG_BYTES)  : CNT_W'(REG_BYTES);

  wire [DATA_W-1:0] mask = in_param ? {DATA_W{1'b1}} >> (DATA_W - PARAM_BITS) :
                           in_prog  ? {DATA_W{1'b1}} :
                                      {DATA_W{1'b1}} >> (DATA_W - REG_BITS);

  wire [DATA_W-1:0] acc_nxt = {acc[DATA_W-9:0], rx_byte};
  wire              hdr_ok  = rx_byte[7:8-ID_W] == dev_id && !rx_byte[0];
  wire              last    = cnt == need - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_HDR0;
      addr    <= '0;
      cnt     <= '0;
      acc     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (rx_end) begin
        st  <= S_HDR0;
        cnt <= '0;
        acc <= '0;
      end else if (rx_valid) begin
        case (st)
          S_HDR0: st <= hdr_ok ? S_HDR1 : S_SKIP;
          S_HDR1: begin
            addr[ADDR_W-1:8] <= rx_byte[HI_W-1:0];
            st <= S_HDR2;
          end
          S_HDR2: begin
            addr[7:0] <= rx_byte;
            cnt <= '0;
            acc <= '0;
            st  <= S_DATA;
          end
          S_DATA: begin
            if (last) begin
              wr_en   <= 1'b1;
              wr_addr <= addr;
              wr_data <= acc_nxt & mask;
              addr    <= addr + ADDR_W'(1);
              cnt     <= '0;
              acc     <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
              acc <= acc_nxt;
            end
          end
          default: st <= S_SKIP;
        endcase
      end
    end
  end

  // R6: one strobe per word, never two in adjacent cycles
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R6: a strobe follows an accepted byte that came without an end strobe
  a_r6_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(rx_valid) && !$past(rx_end)));

  a_r3_param_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < ADDR_W'(PARAM_END)) |-> wr_data[DATA_W-1:PARAM_BITS] == '0);

  a_r5_reg_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= ADDR_W'(PROG_END)) |-> wr_data[DATA_W-1:REG_BITS] == '0);

  // R9 and R10: an ignored transaction never writes
  a_r9_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |=> !wr_en);

  a_r11_end_flush: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |=> (!wr_en && st == S_HDR0));

endmodule

// File: tb/sim_cmd_byte_parser.sv
`timescale 1ns/1ps
module sim_cmd_byte_parser;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  dev_id = 7'h34;
  logic        rx_valid = 0;
  logic [7:0]  rx_byte = 0;
  logic        rx_end = 0;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [39:0] wr_data;

  cmd_byte_parser u0 (.clk(clk), .rst_n(rst_n), .dev_id(dev_id), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_end(rx_end), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  always #2 clk = ~clk;

  int total = 0, bad = 0, wc = 0;
  logic [11:0] la [0:31];
  logic [39:0] ld [0:31];
  bit done = 0;

  always @(negedge clk) if (wr_en && wc < 32) begin
    la[wc] = wr_addr; ld[wc] = wr_data; wc++;
  end

  localparam logic [51:0] VEC [0:5] = '{
    {12'h005, 40'h00F1234567}, {12'h400, 40'h123456789A}, {12'h812, 40'h000000BEEF},
    {12'h3FF, 40'h000ABCDEF0}, {12'h7FF, 40'hFFFFFFFFFF}, {12'hFFF, 40'h0000000001}};

  function automatic int nbytes(logic [11:0] a);
    return a < 1024 ? 4 : a < 2048 ? 5 : 2;
  endfunction
  function automatic logic [39:0] expd(logic [11:0] a, logic [39:0] d);
    return a < 1024 ? d & 40'h000FFFFFFF : a < 2048 ? d : d & 40'h000000FFFF;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask
  task automatic send_end();
    @(negedge clk); rx_end = 1;
    @(negedge clk); rx_end = 0;
  endtask
  task automatic header(logic [6:0] id, bit rd, logic [11:0] a);
    send_byte({id, rd});
    send_byte({4'hA, a[11:8]});
    send_byte(a[7:0]);
  endtask
  task automatic send_word(logic [11:0] a, logic [39:0] d);
    for (int i = nbytes(a) - 1; i >= 0; i--) send_byte(d[i*8 +: 8]);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(wr_en == 0, "R1 strobe low in reset", wr_en, 0);
    rst_n = 1;
    @(negedge clk);
    chk(wr_en == 0 && wc == 0, "R1 idle after reset", wc, 0);

    // table walk: single-word writes, R2 R3 R4 R5 R6
    for (int v = 0; v < 6; v++) begin
      logic [11:0] a; logic [39:0] d;
      a = VEC[v][51:40]; d = VEC[v][39:0];
      base = wc;
      header(7'h34, 0, a);
      send_word(a, d);
      chk(wr_en == 1, "R6 strobe after last byte", wr_en, 1);
      @(negedge clk);
      chk(wr_en == 0, "R6 strobe one cycle", wr_en, 0);
      send_end();
      chk(wc == base + 1, "R6 one write", wc - base, 1);
      chk(la[base] == a, "R2 address", la[base], a);
      chk(ld[base] == expd(a, d), a < 1024 ? "R3 param data" : a < 2048 ? "R4 prog data" : "R5 reg data",
          ld[base], expd(a, d));
    end

    // R7 R8: burst param -> prog
    base = wc;
    header(7'h34, 0, 12'h3FE);
    send_word(12'h3FE, 40'h0011111111);
    send_word(12'h3FF, 40'h0022222222);
    send_word(12'h400, 40'hA5A5A5A5A5);
    send_end();
    chk(wc == base + 3, "R7 burst count", wc - base, 3);
    chk(la[base+1] == 12'h3FF, "R7 increment", la[base+1], 12'h3FF);
    chk(la[base+2] == 12'h400 && ld[base+2] == 40'hA5A5A5A5A5, "R8 param to prog",
        ld[base+2], 40'hA5A5A5A5A5);

    // R8: prog -> reg, length drops to 2
    base = wc;
    header(7'h34, 0, 12'h7FF);
    send_word(12'h7FF, 40'h0102030405);
    send_word(12'h800, 40'h000000C3D4);
    send_word(12'h801, 40'h0000001234);
    send_end();
    chk(wc == base + 3, "R8 prog to reg count", wc - base, 3);
    chk(la[base+1] == 12'h800 && ld[base+1] == 40'hC3D4, "R8 reg word", ld[base+1], 40'hC3D4);
    chk(la[base+2] == 12'h801 && ld[base+2] == 40'h1234, "R8 second reg word", ld[base+2], 40'h1234);

    // R9: foreign identifier
    base = wc;
    header(7'h35, 0, 12'h810);
    send_word(12'h810, 40'h5555);
    send_word(12'h811, 40'h6666);
    send_end();
    chk(wc == base, "R9 foreign id ignored", wc - base, 0);

    // R10: read direction
    header(7'h34, 1, 12'h810);
    send_word(12'h810, 40'h7777);
    send_end();
    chk(wc == base, "R10 read ignored", wc - base, 0);

    // R11: truncated word then fresh header
    header(7'h34, 0, 12'h010);
    send_byte(8'h01); send_byte(8'h02);
    send_end();
    chk(wc == base, "R11 partial discarded", wc - base, 0);
    header(7'h34, 0, 12'h820);
    send_word(12'h820, 40'h9ABC);
    send_end();
    chk(wc == base + 1 && la[base] == 12'h820 && ld[base] == 40'h9ABC, "R11 recovery",
        ld[base], 40'h9ABC);

    // R11: last byte coincides with end
    base = wc;
    header(7'h34, 0, 12'h020);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
    @(negedge clk); rx_valid = 1; rx_byte = 8'h04; rx_end = 1;
    @(negedge clk); rx_valid = 0; rx_end = 0;
    chk(wr_en == 0 && wc == base, "R11 byte with end dropped", wc - base, 0);
    header(7'h34, 0, 12'h900);
    send_word(12'h900, 40'h4242);
    send_end();
    chk(wc == base + 1 && la[base] == 12'h900, "R11 header after end", la[base], 12'h900);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule